// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor datapath that finishes one instruction per clock. It runs register-to-register arithmetic and logic operations, word loads, word stores and branch-on-equal. The core has its own instruction memory and its own data memory. A main decoder and an ALU decoder turn each instruction word into the selects for three multiplexers: the second ALU operand, the register write-back value and the next program counter.

Programs go into the instruction memory through a write port while the core is held in reset. Once reset is released, the program counter starts at zero and moves every clock. Each cycle the core shows its program counter, its register write (enable, index, value) and its data-memory write (enable, address, value) on output ports. A surrounding test or system can follow execution from these ports.

Instruction fields: opcode in bits [31:26], first source register in [25:21], second source or load target in [20:16], R-type destination in [15:11], function code in [5:0], and a 16-bit signed immediate in [15:0].

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o reads 0. Reset clears all registers and every data-memory word to 0.
- R2: Each instruction that is not a taken branch moves pc_o to pc_o+4 at the next rising edge.
- R3: Opcode 000100 compares the two source registers. If they are equal, the next pc_o is pc_o+4 plus the sign-extended immediate shifted left by 2. If they differ, the next pc_o is pc_o+4. This opcode writes no register and no memory.
- R4: Opcode 000000 writes register [15:11] with the result selected by the function code: 100000 add, 100010 subtract (first minus second), 100100 and, 100101 or, 100111 nor. Arithmetic wraps modulo 2^32.
- R5: Function code 101010 writes 1 when the first source is less than the second as signed 32-bit values, and 0 otherwise.
- R6: Opcode 100011 loads into register [20:16] the data-memory word at base register plus sign-extended immediate. Address bits [7:2] select the word, so addresses wrap over 64 words.
- R7: Opcode 101011 stores register [20:16] at base plus sign-extended immediate, using the same word selection as R6. It writes no register.
- R8: Register 0 always reads as 0. A write that targets it still shows on the write ports but has no effect.
- R9: Instruction-memory writes land only while the core is in reset or in its first cycle after reset. Later writes are ignored.
- R10: Any other opcode, and any other R-type function code, writes neither a register nor memory, and the pc advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_we_i | input | 1 | Instruction-memory write strobe |
| imem_waddr_i | input | 6 | Instruction-memory word index |
| imem_wdata_i | input | 32 | Instruction word to store |
| pc_o | output | 32 | Address of the instruction now executing |
| rf_we_o | output | 1 | Register write enable for this instruction |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write-back value |
| dm_we_o | output | 1 | Data-memory write enable |
| dm_addr_o | output | 32 | Data-memory byte address (ALU result) |
| dm_wdata_o | output | 32 | Data-memory store value |

## Verification
All write ports depend combinationally on the instruction addressed by pc_o. They are valid in the same cycle, and the state they describe lands at the following rising edge. A new pc_o and the effect of a write become visible one edge later. The bench samples every port at the falling edge, compares it with an instruction-level model stepped once per cycle, and only then advances the model. Because of this, a wrong branch target, write value or stored word shows up in the cycle it is due.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111,
    ALU_NOR = 4'b1100
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;
    logic    alu_src;
    logic    mem_read;
    logic    mem_write;
    logic    mem_to_reg;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  localparam int NREGS = 1 << AW;

  logic [XLEN-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // index 0 is hardwired to zero
  assign rdata_a_o = (raddr_a_i == '0) ? '0 : regs_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : regs_q[raddr_b_i];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o,
  output logic            zero_o
);
  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      ALU_AND: res_o = a_i & b_i;
      ALU_OR:  res_o = a_i | b_i;
      ALU_ADD: res_o = a_i + b_i;
      ALU_SUB: res_o = a_i - b_i;
      ALU_SLT: res_o = {{(XLEN-1){1'b0}}, lt};
      ALU_NOR: res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode_i,
  input  logic [5:0] funct_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o        = '0;
    ctrl_o.alu_op = ALU_ADD;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
        unique case (funct_i)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_NOR:  ctrl_o.alu_op = ALU_NOR;
          FN_SLT:  ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_read   = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.alu_src   = 1'b1;
        ctrl_o.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.branch = 1'b1;
        ctrl_o.alu_op = ALU_SUB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            imem_we_i,
  input  logic [IAW-1:0]  imem_waddr_i,
  input  logic [XLEN-1:0] imem_wdata_i,
  output logic [XLEN-1:0] pc_o,
  output logic            rf_we_o,
  output logic [RAW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0] rf_wdata_o,
  output logic            dm_we_o,
  output logic [XLEN-1:0] dm_addr_o,
  output logic [XLEN-1:0] dm_wdata_o
);
  logic [XLEN-1:0] pc_q, pc_d, pc_plus4, br_target;
  logic [XLEN-1:0] instr, imm_ext, rs_data, rt_data, src_b, alu_res, mem_rdata;
  logic            alu_zero, run_q;
  alu_op_e         alu_op;
  ctrl_t           ctrl;

  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  // load window: reset plus first cycle out of it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (imem_we_i && !run_q) imem_q[imem_waddr_i] <= imem_wdata_i;
  end

  assign instr = imem_q[pc_q[IAW+1:2]];

  sc_decoder i_dec (
    .opcode_i(instr[31:26]),
    .funct_i (instr[5:0]),
    .ctrl_o  (ctrl)
  );
  assign alu_op = ctrl.alu_op;

  sc_regfile #(.XLEN(XLEN), .AW(RAW)) i_rf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (rf_we_o),
    .waddr_i  (rf_waddr_o),
    .wdata_i  (rf_wdata_o),
    .raddr_a_i(instr[25:21]),
    .raddr_b_i(instr[20:16]),
    .rdata_a_o(rs_data),
    .rdata_b_o(rt_data)
  );

  assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign src_b   = ctrl.alu_src ? imm_ext : rt_data;

  sc_alu #(.XLEN(XLEN)) i_alu (
    .op_i  (alu_op),
    .a_i   (rs_data),
    .b_i   (src_b),
    .res_o (alu_res),
    .zero_o(alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DMEM_WORDS; i++) dmem_q[i] <= '0;
    end else if (ctrl.mem_write) begin
      dmem_q[alu_res[DAW+1:2]] <= rt_data;
    end
  end

  assign mem_rdata = ctrl.mem_read ? dmem_q[alu_res[DAW+1:2]] : '0;

  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign pc_d      = (ctrl.branch && alu_zero) ? br_target : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = ctrl.reg_write;
  assign rf_waddr_o = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_wdata_o = ctrl.mem_to_reg ? mem_rdata : alu_res;
  assign dm_we_o    = ctrl.mem_write;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_data;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_data,
  input logic [XLEN-1:0] rt_data,
  input logic            rf_we,
  input logic            dm_we,
  input alu_op_e         alu_op,
  input logic [XLEN-1:0] alu_res
);
  logic known_op;
  assign known_op = instr[31:26] inside {OP_RTYPE, OP_LOAD, OP_STORE, OP_BEQ};

  a_r2_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] != OP_BEQ) |=> pc_q == $past(pc_q) + 32'd4);

  a_r3_branch_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == OP_BEQ && rs_data == rt_data) |=>
      pc_q == $past(pc_q) + 32'd4 + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  a_r3_branch_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[31:26] == OP_BEQ && rs_data != rt_data) |=> pc_q == $past(pc_q) + 32'd4);

  a_r5_slt_bool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op == ALU_SLT) |-> alu_res[XLEN-1:1] == '0);

  a_r7_store_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_we |-> !rf_we);

  a_r8_zero_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr[25:21] == '0) |-> rs_data == '0);

  a_r10_unknown_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !known_op |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pc_q   (pc_q),
  .instr  (instr),
  .rs_data(rs_data),
  .rt_data(rt_data),
  .rf_we  (rf_we_o),
  .dm_we  (dm_we_o),
  .alu_op (alu_op),
  .alu_res(alu_res)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
  localparam int CLK_NS = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        imem_we_i = 1'b0;
  logic [5:0]  imem_waddr_i = '0;
  logic [31:0] imem_wdata_i = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic [4:0]  rf_waddr_o;
  logic        rf_we_o, dm_we_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] prog  [64];
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  int          r9_idx = -1;

  always #(CLK_NS/2) clk_i = ~clk_i;

  sc_core i_sc_core (.*);

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at pc %h: actual %h expected %h", tag, what, m_pc, act, exp);
    end
  endtask

  task automatic load_prog();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem_we_i = 1'b1; imem_waddr_i = 6'(i); imem_wdata_i = prog[i];
      @(negedge clk_i);
    end
    imem_we_i = 1'b0;
    chk("R1", "pc in reset", pc_o, 32'h0);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    for (int i = 0; i < 64; i++) m_mem[i] = '0;
    m_pc = '0;
    rst_ni = 1'b1;
  endtask

  // one instruction: compare ports, then step the model
  task automatic step_check();
    logic [31:0] ins, a, b, sx, res, nxt, addr;
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    logic        e_we, e_dwe, ok;
    logic [4:0]  e_wa;
    logic [31:0] e_wd;
    string       tag;
    ins = prog[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_reg[rs]; b = m_reg[rt];
    sx = {{16{ins[15]}}, ins[15:0]};
    nxt = m_pc + 4; e_we = 0; e_dwe = 0; e_wa = '0; e_wd = '0; addr = '0; tag = "R2";
    case (op)
      6'b000000: begin
        ok = 1; tag = "R4";
        case (fn)
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b100111: res = ~(a | b);
          6'b101010: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R5"; end
          default:   begin ok = 0; res = '0; tag = "R10"; end
        endcase
        if (ok) begin e_we = 1; e_wa = 5'(rd); e_wd = res; end
        if (ok && (rs == 0 || rd == 0)) tag = "R8";
      end
      6'b100011: begin
        tag = "R6"; addr = a + sx;
        e_we = 1; e_wa = 5'(rt); e_wd = m_mem[addr[7:2]];
      end
      6'b101011: begin
        tag = "R7"; addr = a + sx; e_dwe = 1;
      end
      6'b000100: begin
        tag = "R3";
        if (a == b) nxt = m_pc + 4 + {sx[29:0], 2'b00};
      end
      default: tag = "R10";
    endcase
    if (int'(m_pc[7:2]) == r9_idx) tag = "R9";
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "rf_we", 32'(rf_we_o), 32'(e_we));
    if (e_we) begin
      chk(tag, "rf_waddr", 32'(rf_waddr_o), 32'(e_wa));
      chk(tag, "rf_wdata", rf_wdata_o, e_wd);
    end
    chk(tag, "dm_we", 32'(dm_we_o), 32'(e_dwe));
    if (e_dwe) begin
      chk(tag, "dm_addr", dm_addr_o, addr);
      chk(tag, "dm_wdata", dm_wdata_o, b);
    end
    if (e_we && e_wa != 0) m_reg[e_wa] = e_wd;
    if (e_dwe) m_mem[addr[7:2]] = b;
    m_pc = nxt;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic logic [31:0] rand_instr(int idx);
    int sel, rs, rt, rd;
    logic [5:0] fns [6];
    fns = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b100111, 6'b101010};
    sel = int'($urandom % 10);
    rs = int'($urandom % 8); rt = int'($urandom % 8); rd = int'($urandom % 8);
    if (idx < 2) return enc_r(0, 0, idx + 1, 6'b100111);
    case (sel)
      0, 1, 2, 3, 4: return enc_r(rs, rt, rd, fns[$urandom % 6]);
      5: return enc_i(6'b100011, rs, rt, int'($urandom % 65536));
      6: return enc_i(6'b101011, rs, rt, int'($urandom % 65536));
      7: return enc_i(6'b000100, rs, rt, int'($urandom % 4));
      8: return enc_r(rs, rt, rd, 6'b000011);
      default: return enc_i(6'b111111, rs, rt, 0);
    endcase
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    // directed program
    for (int i = 0; i < 64; i++) prog[i] = '0;
    prog[0]  = enc_r(0, 0, 1, 6'b100111);        // r1 = -1
    prog[1]  = enc_r(1, 1, 2, 6'b100000);        // r2 = -2
    prog[2]  = enc_i(6'b101011, 0, 2, 8);        // store
    prog[3]  = enc_i(6'b100011, 0, 3, 8);        // load back
    prog[4]  = enc_i(6'b000100, 3, 2, 1);        // taken
    prog[5]  = enc_r(1, 1, 6, 6'b100000);        // skipped
    prog[6]  = enc_r(2, 1, 4, 6'b101010);        // slt -> 1
    prog[7]  = enc_r(1, 2, 7, 6'b101010);        // slt -> 0
    prog[8]  = enc_r(1, 1, 0, 6'b100000);        // write r0
    prog[9]  = enc_r(0, 1, 5, 6'b100101);        // r0 still 0
    prog[10] = enc_i(6'b000100, 4, 7, -2);       // not taken
    prog[11] = enc_r(4, 2, 8, 6'b100010);        // 3
    prog[12] = enc_r(8, 1, 9, 6'b100100);
    prog[13] = 32'hFC00_0000;                    // unknown opcode
    prog[14] = enc_r(1, 1, 10, 6'b000001);       // unknown funct
    prog[15] = enc_i(6'b100011, 2, 10, -4);      // wrapped address
    prog[16] = enc_i(6'b000100, 0, 0, -1);       // spin
    load_prog();
    for (int c = 0; c < 24; c++) begin
      if (c == 3) begin
        r9_idx = 11;
        imem_we_i = 1'b1; imem_waddr_i = 6'd11; imem_wdata_i = enc_r(1, 1, 8, 6'b100111);
      end
      step_check();
      @(negedge clk_i);
      imem_we_i = 1'b0;
    end
    r9_idx = -1;
    // random programs
    for (int p = 0; p < 40; p++) begin
      for (int i = 0; i < 64; i++) prog[i] = (i < 48) ? rand_instr(i) : 32'h0;
      load_prog();
      for (int c = 0; c < 70; c++) begin
        step_check();
        @(negedge clk_i);
      end
    end
    finish_run();
  end
endmodule